// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and reports whether the first is greater than, less than or equal to the second, on three separate result lines. It is built from 4-bit slices. Each slice looks at its own pair of nibbles first. It defers to the result handed up from the slice below only when its own nibbles match. The slices are chained so that the most significant slice has the final word, and the top module exposes the same three cascade inputs so that whole comparators can be chained in turn.

The block is purely combinational: there is no clock, no reset and no storage. Operand data is a plain parallel word, not a stream, so there is no valid/ready handshake and no back-pressure. The result follows the inputs within the same time step. For a stand-alone compare, the user ties the equal cascade input high and the other two low.

Top module: `magcmp_wide`

## Requirements
- R1: When A is greater than B as unsigned integers, gt_o is 1 and lt_o and eq_o are 0, whatever the cascade inputs are.
- R2: When A is less than B as unsigned integers, lt_o is 1 and gt_o and eq_o are 0, whatever the cascade inputs are.
- R3: When A equals B, {gt_o, lt_o, eq_o} copies {casc_gt_i, casc_lt_i, casc_eq_i} bit for bit, for all eight input patterns, including those that are not one-hot.
- R4: Whenever exactly one cascade input is high, exactly one of gt_o, lt_o and eq_o is high.
- R5: With the cascade inputs tied to gt=0, lt=0, eq=1, the block is a plain comparator, and eq_o is 1 exactly when A equals B.
- R6: Operands are NIBBLES*4 bits wide with bit 0 least significant. The most significant differing bit decides the order, so a difference in a higher nibble overrides any difference in a lower nibble.
- R7: The outputs depend only on the present inputs. There is no clock and no internal state, and a new result is valid in the same time step as the inputs that produce it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | NIBBLES*4 | First unsigned operand |
| b_i | input | NIBBLES*4 | Second unsigned operand |
| casc_gt_i | input | 1 | Greater result from a less significant comparator |
| casc_lt_i | input | 1 | Less result from a less significant comparator |
| casc_eq_i | input | 1 | Equal result from a less significant comparator |
| gt_o | output | 1 | A greater than B |
| lt_o | output | 1 | A less than B |
| eq_o | output | 1 | A equal to B, or the cascade result when the words match |

## Verification
Each result is due in the same time step as its stimulus, because nothing in the path is registered. The bench applies a new operand pair and cascade pattern, waits one nanosecond so that the combinational chain settles, and then compares all three outputs with values it derives from integer comparison of the operands. The sweep covers every 8-bit operand pair with every one of the eight cascade patterns. The stimulus is paced without reference to the clock edge, so no check depends on the order of events at an edge.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  localparam int unsigned SLICE_W = 4;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmp_res_t;

endpackage

// File: rtl/magcmp_bit_eq.sv
module magcmp_bit_eq #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] same_o
);

  // per-bit match: XNOR of each operand bit pair
  for (genvar i = 0; i < W; i++) begin : g_xnor
    assign same_o[i] = ~(a_i[i] ^ b_i[i]);
  end

endmodule

// File: rtl/magcmp_prio.sv
module magcmp_prio #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] same_i,
  output logic         gt_o,
  output logic         lt_o,
  output logic         all_same_o
);

  // above[i] is high when every bit at or above position i matches
  logic [W:0]   above;
  logic [W-1:0] win_a;
  logic [W-1:0] win_b;

  assign above[W] = 1'b1;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign above[i] = above[i+1] & same_i[i];
    // bit i decides only if all higher bits match
    assign win_a[i] = above[i+1] & a_i[i] & ~b_i[i];
    assign win_b[i] = above[i+1] & ~a_i[i] & b_i[i];
  end

  assign gt_o       = |win_a;
  assign lt_o       = |win_b;
  assign all_same_o = above[0];

endmodule

// File: rtl/magcmp_stage.sv
module magcmp_stage
  import magcmp_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cmp_res_t     casc_i,
  output cmp_res_t     res_o
);

  logic [W-1:0] same;
  logic         loc_gt;
  logic         loc_lt;
  logic         loc_eq;

  magcmp_bit_eq #(.W(W)) u_eq (
    .a_i    (a_i),
    .b_i    (b_i),
    .same_o (same)
  );

  magcmp_prio #(.W(W)) u_prio (
    .a_i        (a_i),
    .b_i        (b_i),
    .same_i     (same),
    .gt_o       (loc_gt),
    .lt_o       (loc_lt),
    .all_same_o (loc_eq)
  );

  // local slice decides unless its nibbles match
  always_comb begin
    if (loc_eq) begin
      res_o = casc_i;
    end else begin
      res_o.gt = loc_gt;
      res_o.lt = loc_lt;
      res_o.eq = 1'b0;
    end
  end

endmodule

// File: rtl/magcmp_wide.sv
module magcmp_wide
  import magcmp_pkg::*;
#(
  parameter int unsigned NIBBLES = 2,
  localparam int unsigned WIDTH  = NIBBLES * SLICE_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             casc_gt_i,
  input  logic             casc_lt_i,
  input  logic             casc_eq_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);

  // link[k] feeds slice k; link[NIBBLES] is the final result
  cmp_res_t link [NIBBLES+1];

  assign link[0].gt = casc_gt_i;
  assign link[0].lt = casc_lt_i;
  assign link[0].eq = casc_eq_i;

  for (genvar k = 0; k < NIBBLES; k++) begin : g_slice
    magcmp_stage #(.W(SLICE_W)) u_stage (
      .a_i    (a_i[k*SLICE_W +: SLICE_W]),
      .b_i    (b_i[k*SLICE_W +: SLICE_W]),
      .casc_i (link[k]),
      .res_o  (link[k+1])
    );
  end

  assign gt_o = link[NIBBLES].gt;
  assign lt_o = link[NIBBLES].lt;
  assign eq_o = link[NIBBLES].eq;

endmodule

// File: rtl/magcmp_wide_chk.sv
module magcmp_wide_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             casc_gt_i,
  input logic             casc_lt_i,
  input logic             casc_eq_i,
  input logic             gt_o,
  input logic             lt_o,
  input logic             eq_o
);

  always_comb begin
    if (a_i > b_i) begin
      AST_GT_WINS: assert (gt_o && !lt_o && !eq_o) else $error("gt result wrong"); // R1
    end
    if (a_i < b_i) begin
      AST_LT_WINS: assert (lt_o && !gt_o && !eq_o) else $error("lt result wrong"); // R2
    end
    if (a_i == b_i) begin
      AST_CASC_COPY: assert ({gt_o, lt_o, eq_o} == {casc_gt_i, casc_lt_i, casc_eq_i}) else $error("cascade not copied"); // R3
    end
    if ($onehot({casc_gt_i, casc_lt_i, casc_eq_i})) begin
      AST_ONEHOT_OUT: assert ($onehot({gt_o, lt_o, eq_o})) else $error("outputs not one-hot"); // R4
    end
    if (!casc_gt_i && !casc_lt_i && casc_eq_i) begin
      AST_PLAIN_EQ: assert (eq_o == (a_i == b_i)) else $error("plain equal wrong"); // R5
    end
  end

endmodule

bind magcmp_wide magcmp_wide_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .casc_gt_i (casc_gt_i),
  .casc_lt_i (casc_lt_i),
  .casc_eq_i (casc_eq_i),
  .gt_o      (gt_o),
  .lt_o      (lt_o),
  .eq_o      (eq_o)
);

// File: tb/magcmp_wide_bench.sv
`timescale 1ns/1ps
module magcmp_wide_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NIB        = 2;
  localparam int W          = NIB * 4;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         cg, cl, ce;
  logic         gt, lt, eq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  magcmp_wide #(.NIBBLES(NIB)) u_magcmp_wide (
    .a_i       (a),
    .b_i       (b),
    .casc_gt_i (cg),
    .casc_lt_i (cl),
    .casc_eq_i (ce),
    .gt_o      (gt),
    .lt_o      (lt),
    .eq_o      (eq)
  );

  task automatic check3(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d casc=%b got=%b exp=%b", req, a, b, {cg, cl, ce}, got, exp);
    end
  endtask

  task automatic check1(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d casc=%b got=%b exp=%b", req, a, b, {cg, cl, ce}, got, exp);
    end
  endtask

  initial begin
    // idle state: zero operands, stand-alone cascade tie-off
    a = '0; b = '0; {cg, cl, ce} = 3'b001;
    #1;
    check3("R5 idle", {gt, lt, eq}, 3'b001);

    // R6: a high-nibble difference beats an opposite low-nibble difference
    a = 8'h1F; b = 8'h20; #1;
    check3("R6 hi-nibble lt", {gt, lt, eq}, 3'b010);
    a = 8'h80; b = 8'h7F; #1;
    check3("R6 msb gt", {gt, lt, eq}, 3'b100);

    // R7: result follows the inputs in the same time step, no clock involved
    a = 8'h33; b = 8'h33; {cg, cl, ce} = 3'b100; #1;
    check3("R7 same-step", {gt, lt, eq}, 3'b100);
    b = 8'h34; #1;
    check3("R7 same-step", {gt, lt, eq}, 3'b010);

    for (int ai = 0; ai < (1 << W); ai++) begin
      for (int bi = 0; bi < (1 << W); bi++) begin
        for (int c = 0; c < 8; c++) begin
          logic [2:0] exp;
          a = ai[W-1:0];
          b = bi[W-1:0];
          {cg, cl, ce} = c[2:0];
          #1;
          if (ai > bi) begin
            exp = 3'b100;
            check3("R1", {gt, lt, eq}, exp);
          end else if (ai < bi) begin
            exp = 3'b010;
            check3("R2", {gt, lt, eq}, exp);
          end else begin
            exp = c[2:0];
            check3("R3", {gt, lt, eq}, exp);
          end
          if (c == 1 || c == 2 || c == 4)
            check1("R4 onehot", ((gt + lt + eq) == 1) ? 1'b1 : 1'b0, 1'b1);
          if (c == 1)
            check1("R5 plain eq", eq, (ai == bi) ? 1'b1 : 1'b0);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule